// File: doc/BRIEF.md
# Low-Order Interleaved Banked Memory

This block is a word-addressed memory split into a power-of-two number of independent banks. The low bits of the word address choose the bank and the remaining upper bits choose the word inside that bank. Consecutive addresses therefore land in different banks. Each bank runs its own access at the same time as the others. Because of this, a run of sequential or strided requests overlaps the long array access of one word with the accesses of the following words. The per-word cost is no longer paid serially.

A single request port takes one word address per cycle, with a valid/ready handshake. Ready drops while the target bank is still working on an earlier request. A bank access has three phases: address delivery, array access and word return. Each phase length is a parameter. A write occupies its bank for the first two phases only and produces no response. A read is given a sequence tag from a small reorder queue. The bank files its word under that tag when the read finishes. The response port then presents read data strictly in the order in which the reads were accepted.

Top module: `interleaved_mem`

## Requirements
- R1: A word address A is served by bank A mod NUM_BANKS, from location A div NUM_BANKS inside that bank. The bank index is the low log2(NUM_BANKS) address bits. Addresses that share a bank but differ in the upper bits hold separate words.
- R2: While a bank is occupied, req_ready is low for any request that targets that bank. After a read is accepted to bank b, a second request to bank b is accepted no earlier than ADDR_CYC+ARRAY_CYC+XFER_CYC+1 cycles after the first.
- R3: Requests to different free banks are accepted on consecutive cycles, one per cycle, with no wait.
- R4: rsp_valid for a read is high in the cycle ADDR_CYC+ARRAY_CYC+XFER_CYC+1 cycles after the cycle in which the read was accepted (req_valid and req_ready both high), provided no earlier read is still waiting.
- R5: Read responses appear in the order the reads were accepted, one response per read, each for exactly one cycle.
- R6: A write occupies its bank for ADDR_CYC+ARRAY_CYC cycles, so the next request to that bank is accepted ADDR_CYC+ARRAY_CYC+1 cycles after the write. A write never raises rsp_valid.
- R7: When ROB_DEPTH reads are accepted and their responses have not yet been presented, req_ready is low for reads. Writes are not held back by this condition.
- R8: After reset, rsp_valid is low and req_ready is high for any address.
- R9: A read returns the data of the most recent earlier accepted write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is taken on this cycle if req_valid is high |
| rsp_valid | output | 1 | Read data present, one cycle per read |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The bench builds the block with four banks, a 6-bit word address, 16-bit data, phase lengths of 2, 5 and 2 cycles, and a reorder queue of depth 2. The short phases keep a full fill of all 64 words and many bank-busy windows inside a brief run. The shallow queue makes the stall on outstanding reads happen with only two reads in flight, separate from any bank conflict. A behavioural model with a response queue and per-bank free times predicts ready, rsp_valid and read data on every clock.

// File: rtl/interleave_pkg.sv
package interleave_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

endpackage

// File: rtl/interleave_bank.sv
module interleave_bank
    import interleave_pkg::*;
#(
    parameter int LOC_W     = 6,
    parameter int DATA_W    = 32,
    parameter int TAG_W     = 3,
    parameter int ADDR_CYC  = 10,
    parameter int ARRAY_CYC = 60,
    parameter int XFER_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  op_e               op_i,
    input  logic [LOC_W-1:0]  loc_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [TAG_W-1:0]  done_tag_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int RD_LAT = ADDR_CYC + ARRAY_CYC + XFER_CYC;
    localparam int WR_LAT = ADDR_CYC + ARRAY_CYC;
    localparam int CNT_W  = $clog2(RD_LAT + 1);
    localparam int DEPTH  = 1 << LOC_W;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        op_e               op;
        logic [LOC_W-1:0]  loc;
        logic [DATA_W-1:0] wdata;
        logic [TAG_W-1:0]  tag;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic last_phase;

    assign last_phase = (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        if (start_i) begin
            st_d.cnt   = (op_i == OP_WRITE) ? CNT_W'(WR_LAT) : CNT_W'(RD_LAT);
            st_d.op    = op_i;
            st_d.loc   = loc_i;
            st_d.wdata = wdata_i;
            st_d.tag   = tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Array update lands at the end of the access phase of a write.
    always_ff @(posedge clk) begin
        if (last_phase && st_q.op == OP_WRITE) begin
            mem_q[st_q.loc] <= st_q.wdata;
        end
    end

    assign busy_o     = (st_q.cnt != '0);
    assign done_o     = last_phase && (st_q.op == OP_READ);
    assign done_tag_o = st_q.tag;
    assign rdata_o    = mem_q[st_q.loc];

    // R2: the router never starts a bank that is still occupied.
    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R4: an occupied bank counts down by one per cycle.
    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/interleave_rob.sv
module interleave_rob #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 8,
    parameter int NUM_SRC = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_i,
    output logic [$clog2(DEPTH)-1:0]         alloc_tag_o,
    output logic                             space_o,
    input  logic [NUM_SRC-1:0]               fill_i,
    input  logic [NUM_SRC-1:0][$clog2(DEPTH)-1:0] fill_tag_i,
    input  logic [NUM_SRC-1:0][DATA_W-1:0]   fill_data_i,
    output logic                             out_valid_o,
    output logic [DATA_W-1:0]                out_data_o
);

    localparam int TAG_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0]             full;
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [TAG_W-1:0]             head;
        logic [TAG_W-1:0]             tail;
        logic [CNT_W-1:0]             count;
    } rob_st_t;

    rob_st_t st_d, st_q;
    logic pop;

    assign pop = st_q.full[st_q.head];

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (fill_i[s]) begin
                st_d.full[fill_tag_i[s]] = 1'b1;
                st_d.data[fill_tag_i[s]] = fill_data_i[s];
            end
        end
        if (pop) begin
            st_d.full[st_q.head] = 1'b0;
            st_d.head            = st_q.head + TAG_W'(1);
        end
        if (alloc_i) begin
            st_d.tail = st_q.tail + TAG_W'(1);
        end
        st_d.count = st_q.count + CNT_W'(alloc_i) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_tag_o = st_q.tail;
    assign space_o     = (st_q.count < CNT_W'(DEPTH));
    assign out_valid_o = pop;
    assign out_data_o  = st_q.data[st_q.head];

    // R7: no read is tagged while every slot is taken.
    a_r7_alloc_room: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> space_o);

    // R5: each presented response moves the head on by one slot.
    a_r5_head_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> (st_q.head == $past(st_q.head) + TAG_W'(1)));

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_fill_chk
            // R5: a bank never files data into a slot still holding a word.
            a_r5_fill_free: assert property (@(posedge clk) disable iff (!rst_n)
                fill_i[s] |-> !st_q.full[fill_tag_i[s]]);
        end
    endgenerate

endmodule

// File: rtl/interleaved_mem.sv
module interleaved_mem
    import interleave_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_BANKS = 4,
    parameter int ROB_DEPTH = 8,
    parameter int ADDR_CYC  = 10,
    parameter int ARRAY_CYC = 60,
    parameter int XFER_CYC  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int LOC_W  = ADDR_W - BANK_W;
    localparam int TAG_W  = $clog2(ROB_DEPTH);

    logic [BANK_W-1:0]                  bank_sel;
    logic [LOC_W-1:0]                   loc;
    logic [NUM_BANKS-1:0]               bank_busy;
    logic [NUM_BANKS-1:0]               bank_start;
    logic [NUM_BANKS-1:0]               bank_done;
    logic [NUM_BANKS-1:0][TAG_W-1:0]    bank_tag;
    logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_rdata;
    logic [TAG_W-1:0]                   next_tag;
    logic                               rob_space;
    logic                               accept;
    op_e                                req_op;

    assign bank_sel  = req_addr[BANK_W-1:0];
    assign loc       = req_addr[ADDR_W-1:BANK_W];
    assign req_op    = req_write ? OP_WRITE : OP_READ;
    assign req_ready = !bank_busy[bank_sel] && (req_write || rob_space);
    assign accept    = req_valid && req_ready;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_start[b] = accept && (bank_sel == BANK_W'(b));

            interleave_bank #(
                .LOC_W    (LOC_W),
                .DATA_W   (DATA_W),
                .TAG_W    (TAG_W),
                .ADDR_CYC (ADDR_CYC),
                .ARRAY_CYC(ARRAY_CYC),
                .XFER_CYC (XFER_CYC)
            ) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .start_i   (bank_start[b]),
                .op_i      (req_op),
                .loc_i     (loc),
                .wdata_i   (req_wdata),
                .tag_i     (next_tag),
                .busy_o    (bank_busy[b]),
                .done_o    (bank_done[b]),
                .done_tag_o(bank_tag[b]),
                .rdata_o   (bank_rdata[b])
            );
        end
    endgenerate

    interleave_rob #(
        .DATA_W (DATA_W),
        .DEPTH  (ROB_DEPTH),
        .NUM_SRC(NUM_BANKS)
    ) u_rob (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_i    (accept && !req_write),
        .alloc_tag_o(next_tag),
        .space_o    (rob_space),
        .fill_i     (bank_done),
        .fill_tag_i (bank_tag),
        .fill_data_i(bank_rdata),
        .out_valid_o(rsp_valid),
        .out_data_o (rsp_rdata)
    );

    // R1: an accepted request starts at most one bank.
    a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_start));

    // R3: every accepted request starts exactly one bank.
    a_r3_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($countones(bank_start) == 1));

endmodule

// File: tb/interleaved_mem_bench.sv
module interleaved_mem_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int RD = 2;
    localparam int AC = 2;
    localparam int AR = 5;
    localparam int XC = 2;
    localparam int RL = AC + AR + XC;
    localparam int WL = AC + AR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    always #10 clk = ~clk;

    interleaved_mem #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .ROB_DEPTH(RD),
        .ADDR_CYC(AC), .ARRAY_CYC(AR), .XFER_CYC(XC)
    ) u_interleaved_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cyc      = 0;
    int    rsp_seen = 0;
    bit    finished = 1'b0;
    string phase    = "R8 reset";

    typedef struct {
        int          due;
        logic [DW-1:0] data;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] mem_m [1 << AW];
    int            free_at [NB];

    task automatic check(input bit ok, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Reference model, checked every cycle away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int  b;
            bit  exp_rdy;
            bit  exp_v;
            b       = int'(req_addr) % NB;
            exp_rdy = (cyc >= free_at[b]) && (req_write || exp_q.size() < RD);
            check(req_ready === exp_rdy, {phase, " ready (R2/R7)"}, 32'(req_ready), 32'(exp_rdy));
            exp_v = (exp_q.size() > 0) && (exp_q[0].due == cyc);
            check(rsp_valid === exp_v, {phase, " rsp_valid (R4/R5/R6)"}, 32'(rsp_valid), 32'(exp_v));
            if (exp_v) begin
                check(rsp_rdata === exp_q[0].data, {phase, " rsp_rdata (R1/R9)"},
                      32'(rsp_rdata), 32'(exp_q[0].data));
                void'(exp_q.pop_front());
            end
            if (rsp_valid) rsp_seen++;
            if (req_valid && exp_rdy) begin
                if (req_write) begin
                    mem_m[req_addr] = req_wdata;
                    free_at[b]      = cyc + WL + 1;
                end else begin
                    exp_q.push_back('{due: cyc + RL + 1, data: mem_m[req_addr]});
                    free_at[b] = cyc + RL + 1;
                end
            end
        end
    end

    task automatic send(input bit w, input int a, input int d, output int waits);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = AW'(a);
        req_wdata = DW'(d);
        waits     = 0;
        forever begin
            @(negedge clk);
            if (req_ready) break;
            waits++;
        end
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        int w;
        int n;
        int seen0;
        for (int i = 0; i < NB; i++) free_at[i] = 0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(req_ready === 1'b1, "R8 ready after reset", 32'(req_ready), 32'd1);
        check(rsp_valid === 1'b0, "R8 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        @(posedge clk);
        #2;

        // R9 / R1: fill every word with a distinct pattern
        phase = "R9 fill";
        for (int a = 0; a < (1 << AW); a++) send(1'b1, a, 16'hA500 + a * 7, w);
        idle(20);

        // R1: words sharing a bank at different locations stay apart
        phase = "R1 mapping";
        send(1'b0, 5, 0, w);
        send(1'b0, 9, 0, w);
        send(1'b0, 13, 0, w);
        send(1'b0, 62, 0, w);
        idle(25);

        // R3: four different banks on consecutive cycles
        phase = "R3 overlap";
        send(1'b0, 0, 0, w);
        check(w == 0, "R3 wait bank0", 32'(w), 32'd0);
        send(1'b0, 1, 0, w);
        check(w == 0, "R3 wait bank1", 32'(w), 32'd0);
        send(1'b1, 2, 16'h1234, w);
        check(w == 0, "R3 wait bank2", 32'(w), 32'd0);
        send(1'b1, 3, 16'h4321, w);
        check(w == 0, "R3 wait bank3", 32'(w), 32'd0);
        idle(25);

        // R2: same bank, back to back reads
        phase = "R2 conflict";
        send(1'b0, 4, 0, w);
        send(1'b0, 8, 0, w);
        check(w == RL, "R2 same-bank read wait", 32'(w), 32'(RL));
        idle(25);

        // R6: writes hold a bank for the first two phases and give no response
        phase = "R6 write";
        seen0 = rsp_seen;
        send(1'b1, 5, 16'hBEEF, w);
        send(1'b1, 9, 16'hCAFE, w);
        check(w == WL, "R6 same-bank write wait", 32'(w), 32'(WL));
        idle(25);
        check(rsp_seen == seen0, "R6 writes give no response", 32'(rsp_seen), 32'(seen0));
        // R9: written values come back
        phase = "R9 readback";
        send(1'b0, 5, 0, w);
        send(1'b0, 9, 0, w);
        idle(25);

        // R4: read latency
        phase = "R4 latency";
        send(1'b0, 6, 0, w);
        n = 0;
        @(negedge clk);
        while (!rsp_valid && n < 100) begin
            n++;
            @(negedge clk);
        end
        check(n == RL, "R4 read latency", 32'(n), 32'(RL));
        idle(25);

        // R7: reorder queue full holds back reads but not writes
        phase = "R7 queue";
        send(1'b0, 0, 0, w);
        send(1'b0, 1, 0, w);
        send(1'b1, 3, 16'h0F0F, w);
        check(w == 0, "R7 write passes full queue", 32'(w), 32'd0);
        send(1'b0, 2, 0, w);
        check(w == RL - 1, "R7 read waits for queue", 32'(w), 32'(RL - 1));
        idle(25);

        // R5: strided read stream, order preserved
        phase = "R5 order";
        for (int k = 0; k < 24; k++) send(1'b0, (k * 3) % (1 << AW), 0, w);
        for (int k = 0; k < 16; k++) send(k % 2 == 0, (k * 5) % (1 << AW), 16'h7000 + k, w);
        idle(30);
        check(exp_q.size() == 0, "R5 all responses seen", 32'(exp_q.size()), 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule